// File: doc/BRIEF.md
# Interrupt and Memory Field Controller

This block is the interrupt and address-extension control for a processor with a 12-bit word. It holds the global interrupt enable, the instruction field, a buffered next instruction field, the data field, the user-mode flag and its buffer, a greater-than flag, and a 7-bit save field. It decodes the processor-control and field-control I/O instructions presented on `ir_i` while `iot_i` is high. For each one it returns an accumulator result, a skip request or a register update in the same cycle.

The surrounding CPU raises `fetch_i` at each instruction boundary, `jump_i` when a jump or subroutine call executes, and `iot_i` when an I/O instruction executes. These are separate cycles. When `int_take_o` rises during a fetch cycle, the CPU replaces that fetch with the interrupt entry: it writes the PC to location 0 and resumes at location 1. In the same cycle the block packs its fields into the save field and clears them. Device behaviour is outside this block. Devices only supply `dev_req_i` and receive `dev_clear_o`.

Top module: `irq_field_ctl`

## Requirements
- R1: During and after reset, interrupts are disabled, the instruction field, data field, user flag and save field read zero, and no field change or enable delay is pending.
- R2: `int_take_o` is high only in a `fetch_i` cycle where interrupts are enabled, neither the enable delay nor the field-change hold is pending, and at least one bit of `dev_req_i` or the internal user-trap request is set.
- R3: After a take, interrupts are disabled, the instruction field, buffer, data field, user flag and user buffer are zero, and the save field holds {user flag, instruction field, data field} from before the take, in bits 6, 5..3 and 2..0.
- R4: Interrupt-on (ir 6001 octal) enables interrupts and arms a delay. The next fetch cannot take an interrupt and releases the delay, so the fetch after that can take one.
- R5: Set-instruction-buffer (ir 62n2 octal, field n in ir[5:3]) loads only the buffer and blocks interrupts. The combined form (62n3 octal) also loads the data field. The next `jump_i` copies the buffer into the instruction field and the user buffer into the user flag, and lifts the block. The instruction field changes at no other time except a take.
- R6: Set-data-field (62n1 octal) loads the data field at once. Read-data-field (6214), read-instruction-field (6224) and read-save-field (6234) return `ac_i` ORed with the data field at bits 5..3, the instruction field at bits 5..3, or the save field at bits 6..0.
- R7: Restore-from-save (6244 octal) loads user buffer, instruction buffer and data field from save-field bits 6, 5..3 and 2..0, and blocks interrupts until the next jump.
- R8: Read-flags (6004 octal) returns link in bit 11, greater-than in bit 10, any-request in bit 9, zero in bit 8, interrupt enable in bit 7 and the save field in bits 6..0, with the link unchanged.
- R9: Write-flags (6005 octal) loads greater-than from ac bit 10, user buffer from bit 6, instruction buffer from bits 5..3 and data field from bits 2..0. It returns the accumulator unchanged with the link taken from bit 11, enables interrupts and blocks them until the next jump.
- R10: Skip requests: skip-if-enabled (6000) skips when enabled and then disables; skip-on-request (6003) skips when any request is set; skip-on-greater (6006) skips when the greater-than flag is set; interrupt-off (6002) disables.
- R11: Clear-all (6007 octal) returns a zero accumulator and link, pulses `dev_clear_o`, disables interrupts and clears the greater-than flag and the user-trap request.
- R12: Any I/O instruction while the user flag is set produces no accumulator write and no skip, changes no field, and sets the user-trap request. That request counts toward R2 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| fetch_i | input | 1 | Instruction boundary; an interrupt may be taken here |
| jump_i | input | 1 | Jump or subroutine call executes this cycle |
| iot_i | input | 1 | I/O instruction in ir_i executes this cycle |
| ir_i | input | 12 | Instruction register |
| ac_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link bit |
| dev_req_i | input | NREQ | Device interrupt requests |
| ac_o | output | 12 | Accumulator result |
| link_o | output | 1 | Link result |
| ac_we_o | output | 1 | ac_o and link_o are to be written back |
| skip_o | output | 1 | Skip the next instruction |
| int_take_o | output | 1 | Interrupt entry replaces this fetch |
| dev_clear_o | output | 1 | Clear all device flags |
| int_en_o | output | 1 | Interrupt enable |
| if_o | output | 3 | Instruction field |
| df_o | output | 3 | Data field |
| uf_o | output | 1 | User mode flag |
| save_field_o | output | 7 | Save field |

## Verification
The bench targets the two hold-off windows. It issues fetches with requests pending right after interrupt-on and right after each field-changing instruction. A design that releases either window early takes an interrupt one instruction too soon, before the return jump has switched fields. It checks that the instruction field stays put until the jump while the data field moves at once; a design that applies the buffer early would run the next instruction from the wrong field. It also verifies the save-field bit order in both packing (take) and unpacking (restore and write-flags), and that a user-mode I/O instruction is suppressed but later forces an interrupt through the trap request.

// File: rtl/irq_field_pkg.sv
`timescale 1ns/1ps
package irq_field_pkg;
  localparam int AW  = 12;        // accumulator width
  localparam int FW  = 3;         // field register width
  localparam int SFW = 2*FW + 1;  // save field: user, ifield, dfield

  localparam logic [2:0] IOT_OPC    = 3'd6;
  localparam logic [5:0] DEV_CPU    = 6'o00;
  localparam logic [2:0] DEV_FLD_HI = 3'd2;

  typedef enum logic [4:0] {
    OP_NONE,
    OP_SKIP_EN,
    OP_INT_ON,
    OP_INT_OFF,
    OP_SKIP_REQ,
    OP_FLAGS_RD,
    OP_FLAGS_WR,
    OP_SKIP_GT,
    OP_CLR_ALL,
    OP_SET_DF,
    OP_SET_IB,
    OP_SET_BOTH,
    OP_RD_DF,
    OP_RD_IF,
    OP_RD_SF,
    OP_RESTORE,
    OP_TRAP
  } iop_e;
endpackage

// File: rtl/irq_field_dec.sv
`timescale 1ns/1ps
module irq_field_dec
  import irq_field_pkg::*;
(
  input  logic          iot_i,
  input  logic [AW-1:0] ir_i,
  input  logic          user_i,
  output iop_e          op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (iot_i && ir_i[11:9] == IOT_OPC) begin
      if (user_i) begin
        op_o = OP_TRAP;
      end else if (ir_i[8:3] == DEV_CPU) begin
        case (ir_i[2:0])
          3'd0: op_o = OP_SKIP_EN;
          3'd1: op_o = OP_INT_ON;
          3'd2: op_o = OP_INT_OFF;
          3'd3: op_o = OP_SKIP_REQ;
          3'd4: op_o = OP_FLAGS_RD;
          3'd5: op_o = OP_FLAGS_WR;
          3'd6: op_o = OP_SKIP_GT;
          default: op_o = OP_CLR_ALL;
        endcase
      end else if (ir_i[8:6] == DEV_FLD_HI) begin
        case (ir_i[2:0])
          3'd1: op_o = OP_SET_DF;
          3'd2: op_o = OP_SET_IB;
          3'd3: op_o = OP_SET_BOTH;
          3'd4: begin
            case (ir_i[5:3])
              3'd1: op_o = OP_RD_DF;
              3'd2: op_o = OP_RD_IF;
              3'd3: op_o = OP_RD_SF;
              3'd4: op_o = OP_RESTORE;
              default: op_o = OP_NONE;
            endcase
          end
          default: op_o = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_field_gate.sv
`timescale 1ns/1ps
module irq_field_gate
  import irq_field_pkg::*;
#(
  parameter int NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_i,
  input  logic            jump_i,
  input  iop_e            op_i,
  input  logic [NREQ-1:0] dev_req_i,
  output logic            int_en_o,
  output logic            ion_pend_o,
  output logic            cif_pend_o,
  output logic            any_req_o,
  output logic            take_o
);
  logic en_q, en_d, en_ld;
  logic ionp_q, ionp_d, ionp_ld;
  logic cifp_q, cifp_d, cifp_ld;
  logic trap_q, trap_d, trap_ld;

  always_comb begin
    any_req_o = (|dev_req_i) | trap_q;
    take_o    = fetch_i & en_q & ~ionp_q & ~cifp_q & any_req_o;

    en_ld = 1'b0;
    en_d  = en_q;
    if (take_o) begin
      en_ld = 1'b1;
      en_d  = 1'b0;
    end else begin
      case (op_i)
        OP_SKIP_EN, OP_INT_OFF, OP_CLR_ALL: begin
          en_ld = 1'b1;
          en_d  = 1'b0;
        end
        OP_INT_ON, OP_FLAGS_WR: begin
          en_ld = 1'b1;
          en_d  = 1'b1;
        end
        default: ;
      endcase
    end

    ionp_ld = 1'b0;
    ionp_d  = ionp_q;
    if (op_i == OP_INT_ON) begin
      ionp_ld = 1'b1;
      ionp_d  = 1'b1;
    end else if (fetch_i) begin
      ionp_ld = 1'b1;
      ionp_d  = 1'b0;
    end

    cifp_ld = 1'b0;
    cifp_d  = cifp_q;
    if (op_i == OP_SET_IB || op_i == OP_SET_BOTH ||
        op_i == OP_RESTORE || op_i == OP_FLAGS_WR) begin
      cifp_ld = 1'b1;
      cifp_d  = 1'b1;
    end else if (jump_i) begin
      cifp_ld = 1'b1;
      cifp_d  = 1'b0;
    end

    trap_ld = 1'b0;
    trap_d  = trap_q;
    if (op_i == OP_TRAP) begin
      trap_ld = 1'b1;
      trap_d  = 1'b1;
    end else if (op_i == OP_CLR_ALL) begin
      trap_ld = 1'b1;
      trap_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ionp_q <= 1'b0;
      cifp_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      if (en_ld)   en_q   <= en_d;
      if (ionp_ld) ionp_q <= ionp_d;
      if (cifp_ld) cifp_q <= cifp_d;
      if (trap_ld) trap_q <= trap_d;
    end
  end

  assign int_en_o   = en_q;
  assign ion_pend_o = ionp_q;
  assign cif_pend_o = cifp_q;
endmodule

// File: rtl/irq_field_regs.sv
`timescale 1ns/1ps
module irq_field_regs
  import irq_field_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_i,
  input  logic           jump_i,
  input  iop_e           op_i,
  input  logic [FW-1:0]  fld_i,
  input  logic           gt_wr_i,
  input  logic [SFW-1:0] sf_wr_i,
  output logic [FW-1:0]  if_o,
  output logic [FW-1:0]  ib_o,
  output logic [FW-1:0]  df_o,
  output logic           uf_o,
  output logic [SFW-1:0] sf_o,
  output logic           gt_o
);
  logic [FW-1:0]  if_q, if_d, ib_q, ib_d, df_q, df_d;
  logic           uf_q, uf_d, ub_q, ub_d, gt_q, gt_d;
  logic [SFW-1:0] sf_q, sf_d;
  logic           if_ld, ib_ld, df_ld, uf_ld, ub_ld, gt_ld, sf_ld;

  always_comb begin
    if_d = if_q; ib_d = ib_q; df_d = df_q;
    uf_d = uf_q; ub_d = ub_q; gt_d = gt_q; sf_d = sf_q;
    if_ld = 1'b0; ib_ld = 1'b0; df_ld = 1'b0;
    uf_ld = 1'b0; ub_ld = 1'b0; gt_ld = 1'b0; sf_ld = 1'b0;

    if (take_i) begin
      sf_d  = {uf_q, if_q, df_q};
      sf_ld = 1'b1;
      if_d = '0; ib_d = '0; df_d = '0; uf_d = 1'b0; ub_d = 1'b0;
      if_ld = 1'b1; ib_ld = 1'b1; df_ld = 1'b1; uf_ld = 1'b1; ub_ld = 1'b1;
    end else begin
      if (jump_i) begin
        if_d  = ib_q;
        uf_d  = ub_q;
        if_ld = 1'b1;
        uf_ld = 1'b1;
      end
      case (op_i)
        OP_SET_DF: begin
          df_d = fld_i; df_ld = 1'b1;
        end
        OP_SET_IB: begin
          ib_d = fld_i; ib_ld = 1'b1;
        end
        OP_SET_BOTH: begin
          df_d = fld_i; df_ld = 1'b1;
          ib_d = fld_i; ib_ld = 1'b1;
        end
        OP_RESTORE: begin
          {ub_d, ib_d, df_d} = sf_q;
          ub_ld = 1'b1; ib_ld = 1'b1; df_ld = 1'b1;
        end
        OP_FLAGS_WR: begin
          {ub_d, ib_d, df_d} = sf_wr_i;
          gt_d = gt_wr_i;
          ub_ld = 1'b1; ib_ld = 1'b1; df_ld = 1'b1; gt_ld = 1'b1;
        end
        OP_CLR_ALL: begin
          gt_d = 1'b0; gt_ld = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_q <= '0; ib_q <= '0; df_q <= '0;
      uf_q <= 1'b0; ub_q <= 1'b0; gt_q <= 1'b0; sf_q <= '0;
    end else begin
      if (if_ld) if_q <= if_d;
      if (ib_ld) ib_q <= ib_d;
      if (df_ld) df_q <= df_d;
      if (uf_ld) uf_q <= uf_d;
      if (ub_ld) ub_q <= ub_d;
      if (gt_ld) gt_q <= gt_d;
      if (sf_ld) sf_q <= sf_d;
    end
  end

  assign if_o = if_q;
  assign ib_o = ib_q;
  assign df_o = df_q;
  assign uf_o = uf_q;
  assign sf_o = sf_q;
  assign gt_o = gt_q;
endmodule

// File: rtl/irq_field_ctl.sv
`timescale 1ns/1ps
module irq_field_ctl
  import irq_field_pkg::*;
#(
  parameter int NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_i,
  input  logic            jump_i,
  input  logic            iot_i,
  input  logic [11:0]     ir_i,
  input  logic [11:0]     ac_i,
  input  logic            link_i,
  input  logic [NREQ-1:0] dev_req_i,
  output logic [11:0]     ac_o,
  output logic            link_o,
  output logic            ac_we_o,
  output logic            skip_o,
  output logic            int_take_o,
  output logic            dev_clear_o,
  output logic            int_en_o,
  output logic [2:0]      if_o,
  output logic [2:0]      df_o,
  output logic            uf_o,
  output logic [6:0]      save_field_o
);
  iop_e           op_w;
  logic           ion_pend_w, cif_pend_w, any_req_w, gt_w;
  logic [FW-1:0]  ib_w;

  irq_field_dec u_dec (
    .iot_i  (iot_i),
    .ir_i   (ir_i),
    .user_i (uf_o),
    .op_o   (op_w)
  );

  irq_field_gate #(.NREQ(NREQ)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_i    (fetch_i),
    .jump_i     (jump_i),
    .op_i       (op_w),
    .dev_req_i  (dev_req_i),
    .int_en_o   (int_en_o),
    .ion_pend_o (ion_pend_w),
    .cif_pend_o (cif_pend_w),
    .any_req_o  (any_req_w),
    .take_o     (int_take_o)
  );

  irq_field_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (int_take_o),
    .jump_i  (jump_i),
    .op_i    (op_w),
    .fld_i   (ir_i[5:3]),
    .gt_wr_i (ac_i[10]),
    .sf_wr_i (ac_i[SFW-1:0]),
    .if_o    (if_o),
    .ib_o    (ib_w),
    .df_o    (df_o),
    .uf_o    (uf_o),
    .sf_o    (save_field_o),
    .gt_o    (gt_w)
  );

  always_comb begin
    ac_o    = ac_i;
    link_o  = link_i;
    ac_we_o = 1'b0;
    skip_o  = 1'b0;
    case (op_w)
      OP_FLAGS_RD: begin
        ac_we_o = 1'b1;
        ac_o    = {link_i, gt_w, any_req_w, 1'b0, int_en_o, save_field_o};
      end
      OP_FLAGS_WR: begin
        ac_we_o = 1'b1;
        link_o  = ac_i[AW-1];
      end
      OP_CLR_ALL: begin
        ac_we_o = 1'b1;
        ac_o    = '0;
        link_o  = 1'b0;
      end
      OP_RD_DF: begin
        ac_we_o = 1'b1;
        ac_o    = ac_i | {{(AW-2*FW){1'b0}}, df_o, {FW{1'b0}}};
      end
      OP_RD_IF: begin
        ac_we_o = 1'b1;
        ac_o    = ac_i | {{(AW-2*FW){1'b0}}, if_o, {FW{1'b0}}};
      end
      OP_RD_SF: begin
        ac_we_o = 1'b1;
        ac_o    = ac_i | {{(AW-SFW){1'b0}}, save_field_o};
      end
      OP_SKIP_EN:  skip_o = int_en_o;
      OP_SKIP_REQ: skip_o = any_req_w;
      OP_SKIP_GT:  skip_o = gt_w;
      default: ;
    endcase
  end

  assign dev_clear_o = (op_w == OP_CLR_ALL);
endmodule

// File: rtl/irq_field_chk.sv
`timescale 1ns/1ps
module irq_field_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_i,
  input logic        jump_i,
  input logic        iot_i,
  input logic [11:0] ir_i,
  input logic        int_take_o,
  input logic        int_en_o,
  input logic        ion_pend,
  input logic        cif_pend,
  input logic [2:0]  if_o,
  input logic [2:0]  ib,
  input logic [2:0]  df_o,
  input logic        uf_o,
  input logic [6:0]  save_field_o,
  input logic        ac_we_o,
  input logic        skip_o
);
  // R2
  take_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_take_o |-> (fetch_i && int_en_o && !ion_pend && !cif_pend));

  // R3
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_take_o |=> (!int_en_o && if_o == 3'd0 && df_o == 3'd0 && !uf_o && ib == 3'd0));

  // R3
  take_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_take_o |=> (save_field_o == $past({uf_o, if_o, df_o})));

  // R4
  ion_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_i && !uf_o && ir_i == 12'o6001) |=> !int_take_o);

  // R5
  if_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_i && !int_take_o) |=> $stable(if_o));

  // R5
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !int_take_o) |=> (if_o == $past(ib)));

  // R6
  set_df_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_i && !uf_o && ir_i[11:6] == 6'o62 && ir_i[2:0] == 3'd1) |=> (df_o == $past(ir_i[5:3])));

  // R12
  user_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_i && uf_o) |-> (!ac_we_o && !skip_o));
endmodule

bind irq_field_ctl irq_field_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_i      (fetch_i),
  .jump_i       (jump_i),
  .iot_i        (iot_i),
  .ir_i         (ir_i),
  .int_take_o   (int_take_o),
  .int_en_o     (int_en_o),
  .ion_pend     (ion_pend_w),
  .cif_pend     (cif_pend_w),
  .if_o         (if_o),
  .ib           (ib_w),
  .df_o         (df_o),
  .uf_o         (uf_o),
  .save_field_o (save_field_o),
  .ac_we_o      (ac_we_o),
  .skip_o       (skip_o)
);

// File: tb/irq_field_ctl_bench.sv
`timescale 1ns/1ps
module irq_field_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_i = 1'b0, jump_i = 1'b0, iot_i = 1'b0, link_i = 1'b0;
  logic [11:0] ir_i = '0, ac_i = '0;
  logic [7:0]  dev_req_i = '0;
  logic [11:0] ac_o;
  logic        link_o, ac_we_o, skip_o, int_take_o, dev_clear_o, int_en_o, uf_o;
  logic [2:0]  if_o, df_o;
  logic [6:0]  save_field_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_field_ctl u_irq_field_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .jump_i(jump_i), .iot_i(iot_i),
    .ir_i(ir_i), .ac_i(ac_i), .link_i(link_i), .dev_req_i(dev_req_i),
    .ac_o(ac_o), .link_o(link_o), .ac_we_o(ac_we_o), .skip_o(skip_o),
    .int_take_o(int_take_o), .dev_clear_o(dev_clear_o), .int_en_o(int_en_o),
    .if_o(if_o), .df_o(df_o), .uf_o(uf_o), .save_field_o(save_field_o)
  );

  typedef struct {
    int          rq;
    bit          c_skip, skip, c_take, take, c_we, we, c_clr, clr;
    logic [11:0] ac;
    bit          link;
    bit          c_fld;
    logic [2:0]  ifv, dfv;
    bit          ufv, c_en, en, c_sf;
    logic [6:0]  sf;
  } exp_t;

  exp_t q[$];

  function automatic exp_t blank(input int r);
    exp_t x;
    x = '{default: 0};
    x.rq = r;
    return x;
  endfunction

  task automatic cmp(input int r, input string what, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL R%0d %s: actual %0o expected %0o", r, what, got, want);
    end
  endtask

  // driver: one instruction-slot per call, expectation queued for the monitor
  task automatic cyc(input bit f, input bit io, input logic [11:0] ir, input bit j,
                     input logic [11:0] a, input bit l, input logic [7:0] rq, input exp_t e);
    @(negedge clk);
    fetch_i = f; iot_i = io; ir_i = ir; jump_i = j; ac_i = a; link_i = l; dev_req_i = rq;
    q.push_back(e);
  endtask

  task automatic idle();
    cyc(0, 0, 12'o0, 0, 12'o0, 0, 8'h00, blank(0));
  endtask

  // monitor: combinational results before the edge, registered state after it
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #1.5;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.c_skip) cmp(e.rq, "skip", skip_o, e.skip);
        if (e.c_take) cmp(e.rq, "take", int_take_o, e.take);
        if (e.c_clr)  cmp(e.rq, "dev_clear", dev_clear_o, e.clr);
        if (e.c_we) begin
          cmp(e.rq, "ac_we", ac_we_o, e.we);
          if (e.we) begin
            cmp(e.rq, "ac", ac_o, e.ac);
            cmp(e.rq, "link", link_o, e.link);
          end
        end
        @(posedge clk);
        #0.5;
        if (e.c_fld) begin
          cmp(e.rq, "ifield", if_o, e.ifv);
          cmp(e.rq, "dfield", df_o, e.dfv);
          cmp(e.rq, "user", uf_o, e.ufv);
        end
        if (e.c_en) cmp(e.rq, "enable", int_en_o, e.en);
        if (e.c_sf) cmp(e.rq, "savefield", save_field_o, e.sf);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state; R2 no take while disabled even with requests
    e = blank(1); e.c_take = 1; e.take = 0; e.c_fld = 1; e.c_en = 1; e.c_sf = 1;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'hFF, e);

    // R6 set data field 5 takes effect at once
    e = blank(6); e.c_fld = 1; e.dfv = 3'd5;
    cyc(0, 1, 12'o6251, 0, 12'o0, 0, 8'h00, e);
    // R6 read data field
    e = blank(6); e.c_we = 1; e.we = 1; e.ac = 12'o7050; e.link = 0;
    cyc(0, 1, 12'o6214, 0, 12'o7000, 0, 8'h00, e);
    // R5 buffer load leaves instruction field
    e = blank(5); e.c_fld = 1; e.ifv = 3'd0; e.dfv = 3'd5;
    cyc(0, 1, 12'o6232, 0, 12'o0, 0, 8'h00, e);
    // R4 enable
    e = blank(4); e.c_en = 1; e.en = 1;
    cyc(0, 1, 12'o6001, 0, 12'o0, 0, 8'h00, e);
    // R4 first fetch after enable: no take
    e = blank(4); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h01, e);
    // R5 field change still holds interrupts off
    e = blank(5); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h01, e);
    // R5 jump applies buffer
    e = blank(5); e.c_fld = 1; e.ifv = 3'd3; e.dfv = 3'd5;
    cyc(0, 0, 12'o0, 1, 12'o0, 0, 8'h00, e);
    // R6 read instruction field
    e = blank(6); e.c_we = 1; e.we = 1; e.ac = 12'o0030;
    cyc(0, 1, 12'o6224, 0, 12'o0, 0, 8'h00, e);
    // R2 no request, no take
    e = blank(2); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h00, e);
    // R3 take with request: fields packed and cleared
    e = blank(3); e.c_take = 1; e.take = 1; e.c_fld = 1; e.c_en = 1; e.en = 0;
    e.c_sf = 1; e.sf = 7'o035;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h80, e);
    // R6 read save field
    e = blank(6); e.c_we = 1; e.we = 1; e.ac = 12'o0035;
    cyc(0, 1, 12'o6234, 0, 12'o0, 0, 8'h00, e);
    // R8 read flags
    e = blank(8); e.c_we = 1; e.we = 1; e.ac = 12'o5035; e.link = 1;
    cyc(0, 1, 12'o6004, 0, 12'o1234, 1, 8'h04, e);
    // R7 restore from save field
    e = blank(7); e.c_fld = 1; e.ifv = 3'd0; e.dfv = 3'd5;
    cyc(0, 1, 12'o6244, 0, 12'o0, 0, 8'h00, e);
    e = blank(7); e.c_en = 1; e.en = 1;
    cyc(0, 1, 12'o6001, 0, 12'o0, 0, 8'h00, e);
    e = blank(7); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h01, e);
    // R7 restore holds interrupts until jump
    e = blank(7); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h01, e);
    e = blank(7); e.c_fld = 1; e.ifv = 3'd3; e.dfv = 3'd5;
    cyc(0, 0, 12'o0, 1, 12'o0, 0, 8'h00, e);
    // R9 write flags
    e = blank(9); e.c_we = 1; e.we = 1; e.ac = 12'o6124; e.link = 1;
    e.c_en = 1; e.en = 1; e.c_fld = 1; e.ifv = 3'd3; e.dfv = 3'd4;
    cyc(0, 1, 12'o6005, 0, 12'o6124, 0, 8'h00, e);
    // R9 greater-than loaded
    e = blank(9); e.c_skip = 1; e.skip = 1;
    cyc(0, 1, 12'o6006, 0, 12'o0, 0, 8'h00, e);
    // R9 write flags holds interrupts until jump
    e = blank(9); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h01, e);
    e = blank(9); e.c_fld = 1; e.ifv = 3'd2; e.dfv = 3'd4; e.ufv = 1;
    cyc(0, 0, 12'o0, 1, 12'o0, 0, 8'h00, e);
    // R12 user mode suppresses the I/O instruction
    e = blank(12); e.c_we = 1; e.we = 0; e.c_skip = 1; e.skip = 0; e.c_en = 1; e.en = 1;
    e.c_fld = 1; e.ifv = 3'd2; e.dfv = 3'd4; e.ufv = 1;
    cyc(0, 1, 12'o6000, 0, 12'o0, 0, 8'h00, e);
    // R12 trap request alone causes a take; R3 packing with user flag
    e = blank(12); e.c_take = 1; e.take = 1; e.c_sf = 1; e.sf = 7'o124;
    e.c_fld = 1; e.c_en = 1; e.en = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h00, e);
    // R10 request skip sees trap
    e = blank(10); e.c_skip = 1; e.skip = 1;
    cyc(0, 1, 12'o6003, 0, 12'o0, 0, 8'h00, e);
    // R10 skip-if-enabled while disabled
    e = blank(10); e.c_skip = 1; e.skip = 0;
    cyc(0, 1, 12'o6000, 0, 12'o0, 0, 8'h00, e);
    cyc(0, 1, 12'o6001, 0, 12'o0, 0, 8'h00, blank(10));
    // R10 skip-if-enabled skips and disables
    e = blank(10); e.c_skip = 1; e.skip = 1; e.c_en = 1; e.en = 0;
    cyc(0, 1, 12'o6000, 0, 12'o0, 0, 8'h00, e);
    cyc(0, 1, 12'o6001, 0, 12'o0, 0, 8'h00, blank(10));
    // R10 interrupt-off
    e = blank(10); e.c_en = 1; e.en = 0;
    cyc(0, 1, 12'o6002, 0, 12'o0, 0, 8'h00, e);
    e = blank(10); e.c_skip = 1; e.skip = 1;
    cyc(0, 1, 12'o6006, 0, 12'o0, 0, 8'h00, e);
    // R11 clear-all
    e = blank(11); e.c_we = 1; e.we = 1; e.ac = 12'o0; e.link = 0;
    e.c_clr = 1; e.clr = 1; e.c_en = 1; e.en = 0;
    cyc(0, 1, 12'o6007, 0, 12'o7777, 1, 8'h00, e);
    e = blank(11); e.c_skip = 1; e.skip = 0; e.c_clr = 1; e.clr = 0;
    cyc(0, 1, 12'o6003, 0, 12'o0, 0, 8'h00, e);
    e = blank(11); e.c_skip = 1; e.skip = 0;
    cyc(0, 1, 12'o6006, 0, 12'o0, 0, 8'h00, e);
    // R4 clean delay: second fetch after enable takes
    cyc(0, 1, 12'o6001, 0, 12'o0, 0, 8'h00, blank(4));
    e = blank(4); e.c_take = 1; e.take = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h02, e);
    e = blank(4); e.c_take = 1; e.take = 1; e.c_en = 1; e.en = 0;
    cyc(1, 0, 12'o0, 0, 12'o0, 0, 8'h02, e);

    repeat (3) idle();
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule